// File: doc/BRIEF.md
# Biphase-Mark Audio Subframe Transmitter

This block turns stereo linear PCM samples into a continuous serial stream of 32-slot audio subframes, alternating between a first and a second channel. Each subframe opens with a synchronising preamble. The preamble is followed by the sample, a validity flag, one user bit, one channel-status bit and a parity bit. The whole line is biphase-mark coded from a fast clock that the block divides down itself. Every subframe is split into 64 half-cells of `HALF_DIV` clocks each.

Software or a DMA engine writes samples into a first-stage holding register for each channel. Writes alternate between the channels, always starting with the first channel. When a subframe for a channel begins, that channel's first-stage sample moves into a second stage and is sent. If no new sample has arrived, the sample held in the second stage is sent again. A sequencer outside the block supplies the user and channel-status bit for each subframe. Clearing the enable forces a clean idle state. Both buffer stages keep their contents while idle.

Top module: `bmc_subframe_tx`

## Requirements
- R1: While enabled, subframes run back to back, each lasting 64*HALF_DIV clocks. `sf_start` is high for exactly the one clock in which half-cell 0 of a subframe is on `sdo`. Half-cell k is on `sdo` from clock 4k to clock 4k+3 after that clock (HALF_DIV=4).
- R2: In slots 4 to 31 the line changes level at every cell boundary. Within a cell it changes level at mid-cell only when that slot's bit is 1.
- R3: Slots 0 to 3 carry an 8-half-cell preamble, sent first half first. It is given as levels XOR-ed with the line level before the subframe: 11101000 for the first channel in frame 0 of a block of `BLOCK_FRAMES` frames, 11100010 for the first channel in every other frame, and 11100100 for the second channel.
- R4: Slots 4 to 27 carry the 24-bit sample, least significant bit first. Slot 28, the validity flag, is always 0.
- R5: Slot 29 carries `user_bit` and slot 30 carries `cstat_bit`, both as sampled on the clock edge that starts the subframe.
- R6: Slot 31 makes the count of ones in slots 4 to 31 even.
- R7: Writes fill the first channel and then the second, alternately. The alternation restarts at the first channel after reset and after every disable. A pending sample is taken by the next subframe of its channel.
- R8: `buf_empty` and `dma_req` are high while the block is running and the first stage of the channel due to be written next is empty. `irq` is a one-clock pulse in the first clock of each such empty period.
- R9: A subframe whose channel has no new sample resends that channel's previously sent sample.
- R10: On the first edge that samples `tx_en` low, the block goes idle. `idle` goes to 1, `sdo` to 0, and `buf_empty`, `dma_req` and `irq` to 0. No subframe starts, and the channel and frame counts return to the first channel and frame 0.
- R11: The edge that first samples `tx_en` high starts a first-channel, frame-0 subframe. Samples written before the idle period are kept and are sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Transmit enable; low forces idle |
| wr_valid | input | 1 | Sample write strobe |
| wr_data | input | 24 | Sample to write |
| user_bit | input | 1 | User bit for the next subframe |
| cstat_bit | input | 1 | Channel-status bit for the next subframe |
| sdo | output | 1 | Biphase-mark serial output |
| sf_start | output | 1 | High in the first clock of each subframe |
| idle | output | 1 | Transmitter idle status |
| buf_empty | output | 1 | First stage of the next channel to write is empty |
| irq | output | 1 | One-clock pulse when `buf_empty` rises |
| dma_req | output | 1 | Request for the next sample write |

## Verification
`sf_start`, the first preamble half-cell and the status outputs each appear one edge after the edge that caused them: the enabling edge, a subframe boundary, a write or the disabling edge. The bench therefore samples them one clock later, at negative edges or just after the positive edge. The monitor samples half-cell k at the clock 4k+1 after `sf_start`, which is the middle of that half-cell. It then decodes preamble, data, flags and parity from levels alone. It checks that successive `sf_start` pulses are exactly 256 clocks apart. Expected items are queued at the clock when a subframe starts and compared once its last half-cell has been seen.

// File: rtl/bmc_tx_pkg.sv
package bmc_tx_pkg;
  localparam int SAMPLE_W = 24;
  localparam int WORD_W   = 28;  // slots 4..31
  localparam int HALVES   = 64;

  typedef logic [7:0] pre_t;
  localparam pre_t PRE_BLOCK = 8'b11101000;
  localparam pre_t PRE_FIRST = 8'b11100010;
  localparam pre_t PRE_SECOND = 8'b11100100;

  // payload of slots 4..31: sample, V=0, user, status, even parity
  function automatic logic [WORD_W-1:0] build_word(logic [SAMPLE_W-1:0] smp,
                                                   logic u, logic c);
    logic [WORD_W-1:0] w;
    w = {1'b0, c, u, 1'b0, smp};
    w[WORD_W-1] = ^w[WORD_W-2:0];
    return w;
  endfunction

  // line level of half-cell idx, given the level of the half before it
  function automatic logic half_level(logic prev, logic base, logic [5:0] idx,
                                      logic [WORD_W-1:0] w, pre_t pre);
    logic [4:0] slot;
    if (idx < 6'd8) return base ^ pre[~idx[2:0]];
    slot = idx[5:1] - 5'd4;
    if (!idx[0]) return ~prev;
    return prev ^ w[slot];
  endfunction
endpackage

// File: rtl/bmc_halfcell_div.sv
module bmc_halfcell_div #(
  parameter int HALF_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (HALF_DIV < 2) ? 1 : $clog2(HALF_DIV);
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (!run)        cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else                  cnt <= cnt + 1'b1;
  end

  assign tick = run && (cnt == LAST);

  p_tick_gap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/pcm_stage_buf.sv
module pcm_stage_buf #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_valid,
  input  logic [W-1:0] wr_data,
  input  logic         ptr_clr,
  input  logic         load,
  input  logic         load_ch,
  output logic [W-1:0] load_sample,
  output logic         next_free
);
  logic [W-1:0] fresh [2];
  logic [W-1:0] held  [2];
  logic [1:0]   full;
  logic [1:0]   take;
  logic         wr_ptr;

  always_comb begin
    for (int c = 0; c < 2; c++)
      take[c] = load && (load_ch == 1'(c)) && full[c];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fresh  <= '{default: '0};
      held   <= '{default: '0};
      full   <= '0;
      wr_ptr <= 1'b0;
    end else begin
      for (int c = 0; c < 2; c++) begin
        if (take[c]) held[c] <= fresh[c];
        if (wr_valid && wr_ptr == 1'(c)) begin
          fresh[c] <= wr_data;
          full[c]  <= 1'b1;
        end else if (take[c]) begin
          full[c] <= 1'b0;
        end
      end
      if (ptr_clr)       wr_ptr <= 1'b0;
      else if (wr_valid) wr_ptr <= ~wr_ptr;
    end
  end

  assign load_sample = full[load_ch] ? fresh[load_ch] : held[load_ch];
  assign next_free   = ~full[wr_ptr];

  p_wr_lands_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> full[$past(wr_ptr)] && fresh[$past(wr_ptr)] == $past(wr_data));
endmodule

// File: rtl/bmc_line_coder.sv
module bmc_line_coder
  import bmc_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              tick,
  input  logic              load,
  input  logic [WORD_W-1:0] word,
  input  pre_t              pre,
  output logic              sdo,
  output logic              last_half
);
  logic [5:0]        hc;
  logic [5:0]        hc_n;
  logic              base;
  logic [WORD_W-1:0] word_q;
  pre_t              pre_q;

  assign hc_n = hc + 6'd1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hc <= '0; base <= 1'b0; sdo <= 1'b0; word_q <= '0; pre_q <= '0;
    end else if (load) begin
      hc     <= '0;
      word_q <= word;
      pre_q  <= pre;
      base   <= sdo;
      sdo    <= half_level(sdo, sdo, 6'd0, word, pre);
    end else if (!run) begin
      hc <= '0; base <= 1'b0; sdo <= 1'b0;
    end else if (tick) begin
      hc  <= hc_n;
      sdo <= half_level(sdo, base, hc_n, word_q, pre_q);
    end
  end

  assign last_half = (hc == 6'(HALVES - 1));

  p_cell_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
    run && tick && !load && hc_n >= 6'd8 && !hc_n[0] |=> sdo != $past(sdo));
  p_pre_flip_r3: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> sdo != $past(sdo));
  p_line_home_r6: assert property (@(posedge clk) disable iff (!rst_n)
    run && last_half |-> sdo == base);
endmodule

// File: rtl/bmc_subframe_tx.sv
module bmc_subframe_tx
  import bmc_tx_pkg::*;
#(
  parameter int HALF_DIV     = 4,
  parameter int BLOCK_FRAMES = 192
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tx_en,
  input  logic                wr_valid,
  input  logic [SAMPLE_W-1:0] wr_data,
  input  logic                user_bit,
  input  logic                cstat_bit,
  output logic                sdo,
  output logic                sf_start,
  output logic                idle,
  output logic                buf_empty,
  output logic                irq,
  output logic                dma_req
);
  localparam int FR_W = $clog2(BLOCK_FRAMES);
  localparam logic [FR_W-1:0] FR_LAST = FR_W'(BLOCK_FRAMES - 1);

  logic            act, chan, empty_q, run, tick, last_half;
  logic            first, wrap, load, nxt_ch, next_free;
  logic [FR_W-1:0] frame, nxt_fr;
  logic [SAMPLE_W-1:0] load_sample;
  logic [WORD_W-1:0]   word;
  pre_t                pre;

  assign run   = act && tx_en;
  assign first = tx_en && !act;
  assign wrap  = run && tick && last_half;
  assign load  = first || wrap;

  assign nxt_ch = first ? 1'b0 : ~chan;
  always_comb begin
    if (first)                nxt_fr = '0;
    else if (!chan)           nxt_fr = frame;
    else if (frame == FR_LAST) nxt_fr = '0;
    else                      nxt_fr = frame + 1'b1;
  end
  assign pre  = nxt_ch ? PRE_SECOND : ((nxt_fr == '0) ? PRE_BLOCK : PRE_FIRST);
  assign word = build_word(load_sample, user_bit, cstat_bit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act <= 1'b0; chan <= 1'b0; frame <= '0; sf_start <= 1'b0; empty_q <= 1'b0;
    end else begin
      act      <= tx_en;
      sf_start <= load;
      empty_q  <= buf_empty;
      if (!tx_en) begin
        chan  <= 1'b0;
        frame <= '0;
      end else if (load) begin
        chan  <= nxt_ch;
        frame <= nxt_fr;
      end
    end
  end

  bmc_halfcell_div #(.HALF_DIV(HALF_DIV)) u_div (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(tick));

  pcm_stage_buf #(.W(SAMPLE_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
    .ptr_clr(act && !tx_en), .load(load), .load_ch(nxt_ch),
    .load_sample(load_sample), .next_free(next_free));

  bmc_line_coder u_coder (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(tick), .load(load),
    .word(word), .pre(pre), .sdo(sdo), .last_half(last_half));

  assign idle      = ~act;
  assign buf_empty = act && next_free;
  assign dma_req   = buf_empty;
  assign irq       = buf_empty && !empty_q;

  p_idle_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !act |-> !sdo && !buf_empty && !dma_req && !irq);
  p_irq_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
  p_start_gap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    sf_start |=> !sf_start);
endmodule

// File: tb/bmc_subframe_tx_bench.sv
module bmc_subframe_tx_bench;
  localparam int NFR = 4;
  localparam int SUB = 256;

  logic clk = 1'b0, rst_n = 1'b0, tx_en = 1'b0, wr_valid = 1'b0;
  logic user_bit = 1'b0, cstat_bit = 1'b0;
  logic [23:0] wr_data = '0;
  wire sdo, sf_start, idle, buf_empty, irq, dma_req;

  always #5 clk = ~clk;

  bmc_subframe_tx #(.HALF_DIV(4), .BLOCK_FRAMES(NFR)) u_bmc_subframe_tx (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .wr_valid(wr_valid),
    .wr_data(wr_data), .user_bit(user_bit), .cstat_bit(cstat_bit),
    .sdo(sdo), .sf_start(sf_start), .idle(idle), .buf_empty(buf_empty),
    .irq(irq), .dma_req(dma_req));

  typedef struct {
    logic [7:0]  pre;
    logic [23:0] smp;
    logic        u, c, resend;
  } exp_t;

  int checks = 0, errors = 0;
  int unsigned cyc = 0;
  exp_t exp_q[$];
  logic [23:0] q0[$], q1[$];
  logic [23:0] last0 = '0, last1 = '0;
  logic bwp = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input logic ok, input string tag,
                     input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  // driver: one write, expectation goes to the channel's queue
  task automatic wr(input logic [23:0] d);
    wr_valid = 1'b1; wr_data = d;
    @(posedge clk); #1;
    wr_valid = 1'b0;
    if (bwp) q1.push_back(d); else q0.push_back(d);
    bwp = ~bwp;
  endtask

  task automatic wr_dma(input logic [23:0] d);
    while (!dma_req) begin @(posedge clk); #1; end
    wr(d);
  endtask

  function automatic logic [23:0] pat(input int i);
    return 24'hA5F00F ^ (24'(i) * 24'h13579B);
  endfunction

  // monitor and scoreboard
  initial begin : monitor
    logic [63:0] s;
    logic [27:0] b;
    logic [7:0]  pa;
    exp_t e;
    logic abort, ok, prev_lvl, have_prev, m_ch;
    int m_fr, nsub;
    int unsigned prev_cyc;
    prev_lvl = 0; have_prev = 0; m_ch = 0; m_fr = 0; nsub = 0; prev_cyc = 0;
    forever begin
      @(negedge clk);
      if (sf_start) begin
        if (have_prev) chk(cyc - prev_cyc == SUB, "R1 subframe period", cyc - prev_cyc, SUB);
        prev_cyc = cyc;
        e.pre = m_ch ? 8'b11100100 : ((m_fr == 0) ? 8'b11101000 : 8'b11100010);
        if (m_ch) begin
          e.resend = (q1.size() == 0);
          if (!e.resend) last1 = q1.pop_front();
          e.smp = last1;
        end else begin
          e.resend = (q0.size() == 0);
          if (!e.resend) last0 = q0.pop_front();
          e.smp = last0;
        end
        e.u = user_bit; e.c = cstat_bit;
        exp_q.push_back(e);
        if (m_ch) m_fr = (m_fr == NFR - 1) ? 0 : m_fr + 1;
        m_ch = ~m_ch;
        nsub++;
        user_bit  = 1'(nsub) ^ 1'(nsub >> 2);
        cstat_bit = 1'(nsub >> 1);
        abort = 0;
        for (int k = 0; k < 64; k++) begin
          repeat ((k == 0) ? 1 : 4) @(negedge clk);
          if (idle) begin abort = 1; break; end
          s[k] = sdo;
        end
        e = exp_q.pop_front();
        if (abort) begin
          m_ch = 0; m_fr = 0; prev_lvl = 0; have_prev = 0;
        end else begin
          for (int i = 0; i < 8; i++) pa[3'(7 - i)] = s[i] ^ prev_lvl;
          ok = 1;
          for (int i = 8; i < 64; i += 2) if (s[i] == s[i-1]) ok = 0;
          for (int j = 0; j < 28; j++) b[j] = s[8 + 2*j] ^ s[9 + 2*j];
          chk(pa == e.pre, "R3 R10 R11 preamble", pa, e.pre);
          chk(ok, "R2 cell boundary edges", ok, 1);
          chk(b[23:0] == e.smp, e.resend ? "R9 resent sample" : "R4 R7 sample", b[23:0], e.smp);
          chk(b[24] == 1'b0, "R4 validity", b[24], 0);
          chk(b[25] == e.u, "R5 user bit", b[25], e.u);
          chk(b[26] == e.c, "R5 status bit", b[26], e.c);
          chk(^b == 1'b0, "R6 even parity", ^b, 0);
          prev_lvl = s[63];
          have_prev = 1;
        end
      end
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    logic bad;
    repeat (3) @(posedge clk); #1;
    chk(idle == 1'b1, "R10 reset idle", idle, 1);
    chk(sdo == 1'b0, "R10 reset line", sdo, 0);
    chk({buf_empty, dma_req, irq} == 3'b000, "R10 reset status", {buf_empty, dma_req, irq}, 0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    wr(24'hFFFFFF);
    wr(24'h000000);
    chk(idle && !dma_req, "R10 idle no request", {idle, dma_req}, 2'b10);
    tx_en = 1'b1;
    @(posedge clk); #1;
    chk(sf_start == 1'b1, "R11 start after enable", sf_start, 1);
    chk(irq && dma_req && buf_empty, "R8 request on consume", {irq, dma_req, buf_empty}, 3'b111);
    @(posedge clk); #1;
    chk(irq == 1'b0, "R8 single pulse", irq, 0);
    wr_dma(pat(0));
    chk(dma_req == 1'b0, "R7 R8 second channel still pending", dma_req, 0);
    for (int i = 1; i < 11; i++) wr_dma(pat(i));
    // underrun: three frames with no writes
    repeat (3 * 2 * SUB) @(posedge clk);
    #1;
    while (!sf_start) begin @(posedge clk); #1; end
    repeat (100) @(posedge clk);
    #1 tx_en = 1'b0;
    @(posedge clk); #1;
    chk(idle == 1'b1, "R10 idle after disable", idle, 1);
    chk(sdo == 1'b0, "R10 line low", sdo, 0);
    chk({buf_empty, dma_req} == 2'b00, "R10 status cleared", {buf_empty, dma_req}, 0);
    bwp = 1'b0;
    bad = 0;
    for (int i = 0; i < 600; i++) begin
      @(posedge clk); #1;
      if (sf_start || sdo || !idle) bad = 1;
    end
    chk(!bad, "R10 quiet while idle", bad, 0);
    tx_en = 1'b1;
    @(posedge clk); #1;
    chk(sf_start == 1'b1, "R11 restart", sf_start, 1);
    repeat (2 * 2 * SUB) @(posedge clk);
    #1;
    for (int i = 20; i < 26; i++) wr_dma(pat(i));
    repeat (5 * 2 * SUB) @(posedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule